// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches the pins of one GPIO bank (up to 32 pins, already synchronised to the clock) and turns pin activity into a single interrupt request. Each pin has its own detection mode. It can be level-sensitive or edge-sensitive, with a polarity choice, and an edge-mode pin can also fire on both edges. Detected events are held in a sticky status register until software clears them.

Software configures and services the block through a simple write port and a combinational read port. The interrupt mask cannot be written directly. Pins are unmasked through a set-only "allow" register and masked through a set-only "block" register, so several agents can change disjoint pins without read-modify-write. Events are latched even while a pin is masked. The request output is the OR of all pending events on unmasked pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A write to address 0 (allow) clears the mask bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their mask state.
- R2: A write to address 1 (block) sets the mask bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their mask state.
- R3: Reading address 2 returns the mask, with bit value 1 meaning masked. The mask changes only through writes to addresses 0 and 1. Reading addresses 0 and 1 returns zero.
- R4: Address 3 holds the event status. Writing 1 to a bit clears it, and writing 0 leaves it alone. An edge-mode bit stays cleared until a new qualifying edge occurs.
- R5: When kind bit (address 4) is 0, the pin is level-sensitive. Its status bit is set on every cycle the pin equals its sense bit (address 5, 1 = active high), so a clear has no lasting effect while the pin stays active.
- R6: When kind bit is 1 and the both bit (address 6) is 0, the status bit is set on a rising edge if sense is 1 and on a falling edge if sense is 0. The opposite edge does not set it.
- R7: When kind is 1 and both is 1, either edge sets the status bit. In level mode the both bit has no effect.
- R8: If a detected event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The request output is 1 exactly when some status bit is set on an unmasked pin. Status bits latch while masked, so a later unmask raises the request for a pending event.
- R10: After reset, all pins are masked, status is zero, and kind, sense and both are zero (level, active-low). The request output is 0.
- R11: Status, kind, sense and both read back at addresses 3, 4, 5 and 6. A register write takes effect at the next clock edge, and a pin change is reflected in status one edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronised pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | NPINS | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | NPINS | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Some properties are checked on every cycle:
- allow and block writes move only the selected mask bits;
- the mask holds steady without such a write;
- pending status bits survive unless cleared;
- a level-active pin always leaves its status bit set;
- the request always matches the pending unmasked events.

The bench scenarios cover the rest:
- edge polarity selection;
- the both-edge option and the fact that it is ignored in level mode;
- set-over-clear priority;
- deferred assertion of the request after unmasking;
- the reset values seen through the read port.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_ALLOW  = 3'd0,
        REG_BLOCK  = 3'd1,
        REG_MASK   = 3'd2,
        REG_STATUS = 3'd3,
        REG_KIND   = 3'd4,
        REG_SENSE  = 3'd5,
        REG_BOTH   = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [NPINS-1:0] kind_i,
    input  logic [NPINS-1:0] sense_i,
    input  logic [NPINS-1:0] both_i,
    output logic [NPINS-1:0] hit_o
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;

        always_comb begin
            rise     = pin_i[g] & ~prev_i[g];
            fall     = ~pin_i[g] & prev_i[g];
            lvl_hit  = ~kind_i[g] & (pin_i[g] == sense_i[g]);
            if (both_i[g]) begin
                edge_hit = kind_i[g] & (rise | fall);
            end else if (sense_i[g]) begin
                edge_hit = kind_i[g] & rise;
            end else begin
                edge_hit = kind_i[g] & fall;
            end
            hit_o[g] = lvl_hit | edge_hit;
        end
    end

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] status_i,
    input  logic [NPINS-1:0] mask_i,
    output logic             irq_o
);

    always_comb begin
        irq_o = |(status_i & ~mask_i);
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [NPINS-1:0] wr_data_i,
    input  logic [2:0]       rd_addr_i,
    output logic [NPINS-1:0] rd_data_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] status;
        logic [NPINS-1:0] kind;
        logic [NPINS-1:0] sense;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] prev;
    } state_t;

    localparam state_t RESET_STATE = '{
        mask:   '1,
        status: '0,
        kind:   '0,
        sense:  '0,
        both:   '0,
        prev:   '0
    };

    state_t           st_d, st_q;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] mask_q, status_q, kind_q, sense_q;

    assign mask_q   = st_q.mask;
    assign status_q = st_q.status;
    assign kind_q   = st_q.kind;
    assign sense_q  = st_q.sense;

    gpio_irq_detect #(.NPINS(NPINS)) i_detect (
        .pin_i   (pin_i),
        .prev_i  (st_q.prev),
        .kind_i  (st_q.kind),
        .sense_i (st_q.sense),
        .both_i  (st_q.both),
        .hit_o   (hit)
    );

    gpio_irq_combine #(.NPINS(NPINS)) i_combine (
        .status_i (st_q.status),
        .mask_i   (st_q.mask),
        .irq_o    (irq_o)
    );

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
        clr       = '0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                REG_ALLOW:  st_d.mask  = st_q.mask & ~wr_data_i;
                REG_BLOCK:  st_d.mask  = st_q.mask | wr_data_i;
                REG_STATUS: clr        = wr_data_i;
                REG_KIND:   st_d.kind  = wr_data_i;
                REG_SENSE:  st_d.sense = wr_data_i;
                REG_BOTH:   st_d.both  = wr_data_i;
                default:    ;
            endcase
        end
        // a fresh event wins over a clear in the same cycle
        st_d.status = (st_q.status & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux
    always_comb begin
        case (reg_addr_e'(rd_addr_i))
            REG_MASK:   rd_data_o = st_q.mask;
            REG_STATUS: rd_data_o = st_q.status;
            REG_KIND:   rd_data_o = st_q.kind;
            REG_SENSE:  rd_data_o = st_q.sense;
            REG_BOTH:   rd_data_o = st_q.both;
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_i,
    input logic             wr_en_i,
    input logic [2:0]       wr_addr_i,
    input logic [NPINS-1:0] wr_data_i,
    input logic             irq_o,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] kind_q,
    input logic [NPINS-1:0] sense_q
);

    logic             wr_allow, wr_block;
    logic [NPINS-1:0] clr_vec, keep_vec, lvl_active;

    always_comb begin
        wr_allow   = wr_en_i && (wr_addr_i == 3'd0);
        wr_block   = wr_en_i && (wr_addr_i == 3'd1);
        clr_vec    = (wr_en_i && (wr_addr_i == 3'd3)) ? wr_data_i : '0;
        keep_vec   = status_q & ~clr_vec;
        lvl_active = ~kind_q & ~(pin_i ^ sense_q);
    end

    assert_allow_unmasks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |=> ((mask_q & $past(wr_data_i)) == '0));

    assert_block_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

    assert_mask_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_allow || wr_block) |=> $stable(mask_q));

    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(keep_vec)) == $past(keep_vec)));

    assert_level_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(lvl_active)) == $past(lvl_active)));

    assert_irq_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(status_q & ~mask_q)));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .kind_q    (kind_q),
    .sense_q   (sense_q)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    import gpio_irq_pkg::*;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N)) i_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input reg_addr_e a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input reg_addr_e a, input logic [N-1:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pins[idx] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R10 mask", REG_MASK, '1);
        rd_check("R10 status", REG_STATUS, '0);
        rd_check("R10 kind", REG_KIND, '0);
        rd_check("R10 sense", REG_SENSE, '0);
        rd_check("R10 both", REG_BOTH, '0);
        check("R10 irq", N'(irq), '0);
    endtask

    task automatic t_mask();
        wr(REG_ALLOW, 32'h0000_00F0);
        rd_check("R1 allow", REG_MASK, 32'hFFFF_FF0F);
        wr(REG_ALLOW, '0);
        rd_check("R1 zero bits", REG_MASK, 32'hFFFF_FF0F);
        wr(REG_BLOCK, 32'h0000_0030);
        rd_check("R2 block", REG_MASK, 32'hFFFF_FF3F);
        wr(REG_BLOCK, '0);
        rd_check("R2 zero bits", REG_MASK, 32'hFFFF_FF3F);
        rd_check("R3 allow reads zero", REG_ALLOW, '0);
        wr(REG_BLOCK, '1);
        rd_check("R3 all masked", REG_MASK, '1);
    endtask

    task automatic t_level();
        set_pin(0, 1'b0);
        rd_check("R5 level set", REG_STATUS, 32'h1);
        check("R9 masked no irq", N'(irq), '0);
        wr(REG_STATUS, 32'h1);
        rd_check("R5 clear while active", REG_STATUS, 32'h1);
        set_pin(0, 1'b1);
        rd_check("R4 sticky after inactive", REG_STATUS, 32'h1);
        wr(REG_STATUS, 32'h1);
        rd_check("R4 cleared", REG_STATUS, '0);
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        rd_check("R9 latched while masked", REG_STATUS, 32'h1);
        check("R9 still no irq", N'(irq), '0);
        wr(REG_ALLOW, 32'h1);
        check("R9 unmask raises irq", N'(irq), 32'h1);
        wr(REG_STATUS, 32'h1);
        check("R9 irq after clear", N'(irq), '0);
        wr(REG_BLOCK, 32'h1);
    endtask

    task automatic t_edge();
        wr(REG_KIND, 32'h2);
        wr(REG_SENSE, 32'h2);
        rd_check("R11 kind readback", REG_KIND, 32'h2);
        rd_check("R6 no event on config", REG_STATUS, '0);
        set_pin(1, 1'b0);
        rd_check("R6 falling ignored when rising", REG_STATUS, '0);
        set_pin(1, 1'b1);
        rd_check("R6 rising sets", REG_STATUS, 32'h2);
        wr(REG_STATUS, 32'h2);
        rd_check("R4 edge stays cleared", REG_STATUS, '0);
        wr(REG_SENSE, '0);
        set_pin(1, 1'b0);
        rd_check("R6 falling sets", REG_STATUS, 32'h2);
    endtask

    task automatic t_set_wins();
        set_pin(1, 1'b1);
        rd_check("R6 rising ignored when falling", REG_STATUS, 32'h2);
        wr(REG_STATUS, 32'h2);
        rd_check("R4 clear before race", REG_STATUS, '0);
        @(negedge clk);
        pins[1] = 1'b0;
        wr_en = 1'b1; wr_addr = REG_STATUS; wr_data = 32'h2;
        @(negedge clk);
        wr_en = 1'b0;
        rd_check("R8 set beats clear", REG_STATUS, 32'h2);
        wr(REG_STATUS, 32'h2);
        rd_check("R8 later clear", REG_STATUS, '0);
    endtask

    task automatic t_both();
        wr(REG_KIND, 32'h6);
        wr(REG_BOTH, 32'h4);
        set_pin(2, 1'b0);
        rd_check("R7 both falling", REG_STATUS, 32'h4);
        wr(REG_STATUS, 32'h4);
        set_pin(2, 1'b1);
        rd_check("R7 both rising", REG_STATUS, 32'h4);
        wr(REG_STATUS, 32'h4);
        wr(REG_BOTH, 32'hC);
        set_pin(3, 1'b0);
        rd_check("R5 level pin3", REG_STATUS, 32'h8);
        @(negedge clk);
        pins[3] = 1'b1;
        wr_en = 1'b1; wr_addr = REG_STATUS; wr_data = 32'h8;
        @(negedge clk);
        wr_en = 1'b0;
        rd_check("R7 both ignored in level", REG_STATUS, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_level();
        t_edge();
        t_set_wins();
        t_both();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule